// File: doc/BRIEF.md
# Redirection-Entry Interrupt Delivery Core

This block sits between a set of interrupt request lines and the fabric that carries interrupt messages to the processors' local interrupt controllers. It holds one pending bit for each input pin. It scans the pins whose entries allow a delivery and turns the lowest-numbered one into a single delivery request. That request carries the entry's destination, destination mode, delivery mode, vector and trigger mode, and it waits on a valid/ready handshake. The redirection entries arrive from outside as live configuration inputs. The block owns only the remote-IRR bit of each entry and reports it back on `rirr_o`.

Edge-configured pins latch a request on a rising input and lose it once it is delivered. Level-configured pins follow their input. After a level delivery, a remote-IRR flag blocks that pin until an end-of-interrupt with the entry's vector arrives. If the line is still high at that point, the pin is delivered again. For the external-interrupt delivery mode (code 3'b111), the vector is fetched from a legacy controller through a request/acknowledge pair before the delivery goes out. Legacy request line 0 lands on pin 2, and pin 0 has no source.

Top module: `irq_redir_core`

## Requirements
- R1: An edge-configured pin that is masked ignores a rising input, so a later unmask produces no delivery. An unmasked edge pin latches a request on a rising input.
- R2: A level-configured pin's pending bit tracks its input. A level pulse that ends while the entry is masked leaves nothing to deliver after unmasking.
- R3: Delivering an edge pin clears its request, so one rising edge gives exactly one delivery. Delivering a level pin sets that pin's bit in `rirr_o` to 1.
- R4: A level pin whose remote-IRR bit is 1 produces no delivery, even if its input stays high or rises again.
- R5: An end-of-interrupt clears remote-IRR only on entries whose vector equals `eoi_vector_i`; other entries keep their bit. If the cleared pin is unmasked and its input is still high, it is delivered again.
- R6: A masked entry (mask bit 1) never produces a delivery. A level pin that is high while masked is delivered once it is unmasked.
- R7: With delivery mode 3'b111, the block raises `xv_req_o` and holds `dlv_valid_o` low until `xv_ack_i`. The delivered vector is `xv_vector_i` as sampled with the acknowledge, not the entry's vector.
- R8: Legacy line 0 drives pin 2 (together with line 2). Pin 0 never receives a request. Every other line n drives pin n.
- R9: When several pins can be delivered, they go out in ascending pin index order.
- R10: The delivery fields stay stable while `dlv_valid_o` is 1 and `dlv_ready_i` is 0. Only one delivery or vector fetch is outstanding at a time.
- R11: Reset clears every pending bit and remote-IRR bit and drops `dlv_valid_o` and `xv_req_o`.
- R12: An entry configured for edge trigger reports remote-IRR 0.
- R13: A delivery carries the selected entry's destination, destination mode, delivery mode and vector, and its trigger mode (1 = level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_PINS | Raw request lines, legacy numbering |
| cfg_mask_i | input | NUM_PINS | Per-entry mask, 1 = masked |
| cfg_level_i | input | NUM_PINS | Per-entry trigger, 1 = level, 0 = edge |
| cfg_dest_mode_i | input | NUM_PINS | Per-entry destination mode |
| cfg_mode_i | input | NUM_PINS*3 | Per-entry delivery mode, 3'b111 = external vector |
| cfg_vector_i | input | NUM_PINS*8 | Per-entry vector |
| cfg_dest_i | input | NUM_PINS*8 | Per-entry destination |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector being acknowledged |
| rirr_o | output | NUM_PINS | Remote-IRR bit of each entry |
| dlv_valid_o | output | 1 | Delivery request valid |
| dlv_ready_i | input | 1 | Delivery request accepted |
| dlv_dest_o | output | 8 | Destination |
| dlv_dest_mode_o | output | 1 | Destination mode |
| dlv_mode_o | output | 3 | Delivery mode |
| dlv_vector_o | output | 8 | Vector |
| dlv_level_o | output | 1 | Trigger mode, 1 = level |
| xv_req_o | output | 1 | Vector fetch request to legacy controller |
| xv_ack_i | input | 1 | Vector fetch acknowledge |
| xv_vector_i | input | 8 | Fetched vector, valid with acknowledge |

## Verification
The bench targets the gating of level pins. It holds a line high after its delivery, re-raises it, and sends an end-of-interrupt with a wrong vector and then a right one. A design that let remote-IRR slip would deliver repeatedly, and one that ignored the vector compare would release on the wrong acknowledge. It also pulses a masked edge pin and a masked level pin and then unmasks them. A design that latched the edge pin, or froze the level pin's pending bit, would deliver a request that should not exist. Three simultaneous edges check the ascending order, and a line-0 stimulus with only pin 0 unmasked catches a missing alias. The external-vector path is stalled with the ready input low to show that the request waits for the acknowledge and then stays stable.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_EXTVEC = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_mode;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
        logic              level;
    } dlv_t;
endpackage

// File: rtl/irq_redir_route.sv
module irq_redir_route #(
    parameter int NUM_PINS  = 24,
    parameter int ALIAS_SRC = 0,
    parameter int ALIAS_DST = 2
) (
    input  logic [NUM_PINS-1:0] line_i,
    output logic [NUM_PINS-1:0] pin_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        if (g == ALIAS_SRC) begin : g_src
            assign pin_o[g] = 1'b0;
        end else if (g == ALIAS_DST) begin : g_dst
            assign pin_o[g] = line_i[g] | line_i[ALIAS_SRC];
        end else begin : g_thru
            assign pin_o[g] = line_i[g];
        end
    end
endmodule

// File: rtl/irq_redir_arbiter.sv
module irq_redir_arbiter #(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] pend_i,
    input  logic [NUM_PINS-1:0] rirr_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic [NUM_PINS-1:0] level_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [NUM_PINS-1:0] elig;

    assign elig = pend_i & ~mask_i & ~(rirr_i & level_i);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_redir_state.sv
module irq_redir_state
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_PINS-1:0]       pin_i,
    input  logic [NUM_PINS-1:0]       cfg_mask_i,
    input  logic [NUM_PINS-1:0]       cfg_level_i,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vector_i,
    input  logic                      eoi_valid_i,
    input  logic [VEC_W-1:0]          eoi_vector_i,
    input  logic                      take_i,
    input  logic [IDX_W-1:0]          take_idx_i,
    output logic [NUM_PINS-1:0]       pend_o,
    output logic [NUM_PINS-1:0]       rirr_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] pend;
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] rirr;
    } pin_state_t;

    pin_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = pin_i;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_level_i[i]) begin
                s_d.pend[i] = pin_i[i];
            end else begin
                if (take_i && take_idx_i == IDX_W'(i)) begin
                    s_d.pend[i] = 1'b0;
                end
                if (pin_i[i] && !s_q.prev[i] && !cfg_mask_i[i]) begin
                    s_d.pend[i] = 1'b1;
                end
            end
            if (eoi_valid_i && s_q.rirr[i] &&
                cfg_vector_i[i*VEC_W +: VEC_W] == eoi_vector_i) begin
                s_d.rirr[i] = 1'b0;
            end
            if (take_i && take_idx_i == IDX_W'(i) && cfg_level_i[i]) begin
                s_d.rirr[i] = 1'b1;
            end
            if (!cfg_level_i[i]) begin
                s_d.rirr[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign rirr_o = s_q.rirr;

    // R4: a level pin is never granted while its remote-IRR is held
    a_r4_rirr_gates_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && cfg_level_i[take_idx_i]) |-> !s_q.rirr[take_idx_i]);

    // R12: an entry configured for edge shows no remote-IRR one cycle later
    a_r12_edge_no_rirr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((s_q.rirr & ~$past(cfg_level_i)) == '0));
endmodule

// File: rtl/irq_redir_core.sv
module irq_redir_core
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_PINS-1:0]        line_i,
    input  logic [NUM_PINS-1:0]        cfg_mask_i,
    input  logic [NUM_PINS-1:0]        cfg_level_i,
    input  logic [NUM_PINS-1:0]        cfg_dest_mode_i,
    input  logic [NUM_PINS*MODE_W-1:0] cfg_mode_i,
    input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector_i,
    input  logic [NUM_PINS*DEST_W-1:0] cfg_dest_i,
    input  logic                       eoi_valid_i,
    input  logic [VEC_W-1:0]           eoi_vector_i,
    output logic [NUM_PINS-1:0]        rirr_o,
    output logic                       dlv_valid_o,
    input  logic                       dlv_ready_i,
    output logic [DEST_W-1:0]          dlv_dest_o,
    output logic                       dlv_dest_mode_o,
    output logic [MODE_W-1:0]          dlv_mode_o,
    output logic [VEC_W-1:0]           dlv_vector_o,
    output logic                       dlv_level_o,
    output logic                       xv_req_o,
    input  logic                       xv_ack_i,
    input  logic [VEC_W-1:0]           xv_vector_i
);
    localparam int IDX_W = $clog2(NUM_PINS);

    typedef struct packed {
        phase_e phase;
        dlv_t   dlv;
    } core_t;

    core_t c_d, c_q;

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pend;
    logic                sel_any;
    logic [IDX_W-1:0]    sel_idx;
    logic                take;

    irq_redir_route #(.NUM_PINS(NUM_PINS)) u_route (
        .line_i (line_i),
        .pin_o  (pin_lvl)
    );

    irq_redir_state #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pin_i        (pin_lvl),
        .cfg_mask_i   (cfg_mask_i),
        .cfg_level_i  (cfg_level_i),
        .cfg_vector_i (cfg_vector_i),
        .eoi_valid_i  (eoi_valid_i),
        .eoi_vector_i (eoi_vector_i),
        .take_i       (take),
        .take_idx_i   (sel_idx),
        .pend_o       (pend),
        .rirr_o       (rirr_o)
    );

    irq_redir_arbiter #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_arb (
        .pend_i  (pend),
        .rirr_i  (rirr_o),
        .mask_i  (cfg_mask_i),
        .level_i (cfg_level_i),
        .any_o   (sel_any),
        .idx_o   (sel_idx)
    );

    always_comb begin
        c_d  = c_q;
        take = 1'b0;
        unique case (c_q.phase)
            ST_IDLE: begin
                if (sel_any) begin
                    take               = 1'b1;
                    c_d.dlv.dest       = cfg_dest_i[int'(sel_idx)*DEST_W +: DEST_W];
                    c_d.dlv.dest_mode  = cfg_dest_mode_i[sel_idx];
                    c_d.dlv.mode       = cfg_mode_i[int'(sel_idx)*MODE_W +: MODE_W];
                    c_d.dlv.vector     = cfg_vector_i[int'(sel_idx)*VEC_W +: VEC_W];
                    c_d.dlv.level      = cfg_level_i[sel_idx];
                    c_d.phase          = (cfg_mode_i[int'(sel_idx)*MODE_W +: MODE_W] == MODE_EXTVEC)
                                         ? ST_FETCH : ST_SEND;
                end
            end
            ST_FETCH: begin
                if (xv_ack_i) begin
                    c_d.dlv.vector = xv_vector_i;
                    c_d.phase      = ST_SEND;
                end
            end
            ST_SEND: begin
                if (dlv_ready_i) begin
                    c_d.phase = ST_IDLE;
                end
            end
            default: c_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{phase: ST_IDLE, dlv: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign dlv_valid_o     = (c_q.phase == ST_SEND);
    assign xv_req_o        = (c_q.phase == ST_FETCH);
    assign dlv_dest_o      = c_q.dlv.dest;
    assign dlv_dest_mode_o = c_q.dlv.dest_mode;
    assign dlv_mode_o      = c_q.dlv.mode;
    assign dlv_vector_o    = c_q.dlv.vector;
    assign dlv_level_o     = c_q.dlv.level;

    // R10: request and its fields hold until accepted
    a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dlv_valid_o && !dlv_ready_i) |=> (dlv_valid_o && $stable(c_q.dlv)));

    // R7: vector fetch waits for acknowledge, no delivery meanwhile
    a_r7_fetch_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xv_req_o && !xv_ack_i) |=> (xv_req_o && !dlv_valid_o));

    // R6: the arbiter never grants a masked entry
    a_r6_no_masked_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> !cfg_mask_i[sel_idx]);
endmodule

// File: tb/irq_redir_core_tb_top.sv
module irq_redir_core_tb_top;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [N-1:0]  line = '0;
    logic [N-1:0]  cfg_mask = '1;
    logic [N-1:0]  cfg_level = '0;
    logic [N-1:0]  cfg_dm = '0;
    logic [N*3-1:0] cfg_mode = '0;
    logic [N*8-1:0] cfg_vec = '0;
    logic [N*8-1:0] cfg_dest = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vec = '0;
    logic [N-1:0]  rirr;
    logic          dlv_valid;
    logic          dlv_ready = 1'b0;
    logic [7:0]    dlv_dest;
    logic          dlv_dm;
    logic [2:0]    dlv_mode;
    logic [7:0]    dlv_vec;
    logic          dlv_level;
    logic          xv_req;
    logic          xv_ack = 1'b0;
    logic [7:0]    xv_vec = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_redir_core #(.NUM_PINS(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .line_i(line),
        .cfg_mask_i(cfg_mask), .cfg_level_i(cfg_level), .cfg_dest_mode_i(cfg_dm),
        .cfg_mode_i(cfg_mode), .cfg_vector_i(cfg_vec), .cfg_dest_i(cfg_dest),
        .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vec), .rirr_o(rirr),
        .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready), .dlv_dest_o(dlv_dest),
        .dlv_dest_mode_o(dlv_dm), .dlv_mode_o(dlv_mode), .dlv_vector_o(dlv_vec),
        .dlv_level_o(dlv_level), .xv_req_o(xv_req), .xv_ack_i(xv_ack),
        .xv_vector_i(xv_vec)
    );

    typedef struct packed {
        logic [4:0] line;
        logic [4:0] pin;
        logic       lvl;
        logic       dm;
        logic [2:0] md;
        logic [7:0] vec;
        logic [7:0] dest;
    } row_t;

    localparam row_t TBL [6] = '{
        '{5'd5,  5'd5,  1'b0, 1'b0, 3'b000, 8'h31, 8'h01},
        '{5'd0,  5'd2,  1'b0, 1'b1, 3'b000, 8'h40, 8'h02},
        '{5'd23, 5'd23, 1'b1, 1'b0, 3'b001, 8'h55, 8'h10},
        '{5'd9,  5'd9,  1'b1, 1'b1, 3'b100, 8'h62, 8'h7F},
        '{5'd1,  5'd1,  1'b0, 1'b0, 3'b010, 8'h0A, 8'hAA},
        '{5'd12, 5'd12, 1'b1, 1'b0, 3'b000, 8'hC3, 8'h05}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_entry(input int p, input bit msk, input bit lvl, input bit dm,
                             input logic [2:0] md, input logic [7:0] v, input logic [7:0] d);
        cfg_mask[p]       = msk;
        cfg_level[p]      = lvl;
        cfg_dm[p]         = dm;
        cfg_mode[p*3 +: 3] = md;
        cfg_vec[p*8 +: 8] = v;
        cfg_dest[p*8 +: 8] = d;
    endtask

    task automatic wait_valid(input int max, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < max; k++) begin
            if (dlv_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        eoi_valid = 1'b1;
        eoi_vec   = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        logic [7:0] got [3];
        tick(3);
        // R11: reset state
        check_eq("R11", "valid in reset", 32'(dlv_valid), 0);
        check_eq("R11", "rirr in reset", 32'(rirr), 0);
        check_eq("R11", "xv_req in reset", 32'(xv_req), 0);
        rst_ni = 1'b1;
        tick(2);

        // table walk: R13 fields, R8 mapping, R3 pending/rirr, R4, R5
        for (int e = 0; e < 6; e++) begin
            cfg_mask = '1;
            line     = '0;
            set_entry(int'(TBL[e].pin), 1'b0, TBL[e].lvl, TBL[e].dm, TBL[e].md,
                      TBL[e].vec, TBL[e].dest);
            tick(2);
            line[TBL[e].line] = 1'b1;
            wait_valid(20, seen);
            check_eq("R8", "delivery seen for line", 32'(seen), 1);
            check_eq("R13", "vector", 32'(dlv_vec), 32'(TBL[e].vec));
            check_eq("R13", "dest", 32'(dlv_dest), 32'(TBL[e].dest));
            check_eq("R13", "mode", 32'(dlv_mode), 32'(TBL[e].md));
            check_eq("R13", "dest mode", 32'(dlv_dm), 32'(TBL[e].dm));
            check_eq("R13", "trigger", 32'(dlv_level), 32'(TBL[e].lvl));
            accept();
            if (!TBL[e].lvl) begin
                line[TBL[e].line] = 1'b0;
                tick(8);
                check_eq("R3", "edge delivered once", 32'(dlv_valid), 0);
            end else begin
                check_eq("R3", "level sets rirr", 32'(rirr[TBL[e].pin]), 1);
                tick(8);
                check_eq("R4", "no redelivery while rirr", 32'(dlv_valid), 0);
                line[TBL[e].line] = 1'b0;
                tick(2);
                send_eoi(TBL[e].vec);
                tick(2);
                check_eq("R5", "eoi clears rirr", 32'(rirr[TBL[e].pin]), 0);
                check_eq("R5", "no redelivery when low", 32'(dlv_valid), 0);
            end
        end
        cfg_mask = '1;
        line     = '0;
        tick(2);

        // R8: pin 0 has no source
        set_entry(0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h01, 8'h01);
        line[0] = 1'b1;
        tick(10);
        check_eq("R8", "pin 0 unreachable", 32'(dlv_valid), 0);
        line[0] = 1'b0;
        cfg_mask[0] = 1'b1;
        tick(2);

        // R1: masked edge ignored
        set_entry(4, 1'b1, 1'b0, 1'b0, 3'b000, 8'h44, 8'h04);
        line[4] = 1'b1;
        tick(4);
        line[4] = 1'b0;
        tick(2);
        cfg_mask[4] = 1'b0;
        tick(10);
        check_eq("R1", "masked edge ignored", 32'(dlv_valid), 0);
        line[4] = 1'b1;
        wait_valid(20, seen);
        check_eq("R1", "unmasked edge latched", 32'(seen), 1);
        check_eq("R1", "edge vector", 32'(dlv_vec), 32'h44);
        accept();
        line[4] = 1'b0;
        cfg_mask[4] = 1'b1;
        tick(2);

        // R2: level pulse ending while masked leaves nothing
        set_entry(6, 1'b1, 1'b1, 1'b0, 3'b000, 8'h66, 8'h06);
        line[6] = 1'b1;
        tick(3);
        line[6] = 1'b0;
        tick(3);
        cfg_mask[6] = 1'b0;
        tick(10);
        check_eq("R2", "level pending follows input", 32'(dlv_valid), 0);

        // R6: masked level held, delivered on unmask
        cfg_mask[6] = 1'b1;
        line[6] = 1'b1;
        tick(6);
        check_eq("R6", "masked no delivery", 32'(dlv_valid), 0);
        cfg_mask[6] = 1'b0;
        wait_valid(20, seen);
        check_eq("R6", "delivered after unmask", 32'(seen), 1);
        check_eq("R6", "vector", 32'(dlv_vec), 32'h66);
        accept();
        check_eq("R3", "rirr set pin 6", 32'(rirr[6]), 1);

        // R4: held high and re-raised, still gated
        tick(10);
        check_eq("R4", "held high gated", 32'(dlv_valid), 0);
        line[6] = 1'b0;
        tick(2);
        line[6] = 1'b1;
        tick(10);
        check_eq("R4", "re-raised gated", 32'(dlv_valid), 0);

        // R5: wrong vector keeps rirr, right vector redelivers
        send_eoi(8'h67);
        tick(2);
        check_eq("R5", "wrong eoi keeps rirr", 32'(rirr[6]), 1);
        check_eq("R5", "wrong eoi no delivery", 32'(dlv_valid), 0);
        send_eoi(8'h66);
        wait_valid(20, seen);
        check_eq("R5", "redelivery while high", 32'(seen), 1);
        accept();
        check_eq("R5", "rirr set again", 32'(rirr[6]), 1);

        // R12: switching to edge clears rirr
        cfg_mask[6] = 1'b1;
        tick(1);
        cfg_level[6] = 1'b0;
        tick(2);
        check_eq("R12", "edge entry rirr", 32'(rirr[6]), 0);
        line[6] = 1'b0;
        tick(2);

        // R9: ascending order
        set_entry(3, 1'b0, 1'b0, 1'b0, 3'b000, 8'h23, 8'h00);
        set_entry(7, 1'b0, 1'b0, 1'b0, 3'b000, 8'h27, 8'h00);
        set_entry(10, 1'b0, 1'b0, 1'b0, 3'b000, 8'h2A, 8'h00);
        tick(1);
        line[10] = 1'b1;
        line[3]  = 1'b1;
        line[7]  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_valid(20, seen);
            got[k] = seen ? dlv_vec : 8'h00;
            accept();
        end
        check_eq("R9", "first", 32'(got[0]), 32'h23);
        check_eq("R9", "second", 32'(got[1]), 32'h27);
        check_eq("R9", "third", 32'(got[2]), 32'h2A);
        line = '0;
        cfg_mask = '1;
        tick(2);

        // R7 / R10: external vector fetch and hold
        set_entry(8, 1'b0, 1'b0, 1'b0, 3'b111, 8'h11, 8'h08);
        line[8] = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (xv_req) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check_eq("R7", "fetch requested", 32'(seen), 1);
        tick(3);
        check_eq("R7", "stall before ack", 32'(dlv_valid), 0);
        check_eq("R7", "request held", 32'(xv_req), 1);
        xv_vec = 8'h99;
        xv_ack = 1'b1;
        @(negedge clk);
        xv_ack = 1'b0;
        xv_vec = 8'h00;
        check_eq("R7", "valid after ack", 32'(dlv_valid), 1);
        check_eq("R7", "fetched vector", 32'(dlv_vec), 32'h99);
        check_eq("R10", "no fetch while sending", 32'(xv_req), 0);
        tick(4);
        check_eq("R10", "valid held", 32'(dlv_valid), 1);
        check_eq("R10", "vector held", 32'(dlv_vec), 32'h99);
        check_eq("R10", "dest held", 32'(dlv_dest), 32'h08);
        accept();
        check_eq("R10", "valid drops after accept", 32'(dlv_valid), 0);
        line[8] = 1'b0;
        cfg_mask[8] = 1'b1;
        tick(2);

        // R11: reset mid-run clears rirr
        set_entry(6, 1'b0, 1'b1, 1'b0, 3'b000, 8'h66, 8'h06);
        line[6] = 1'b1;
        wait_valid(20, seen);
        accept();
        check_eq("R11", "rirr before reset", 32'(rirr[6]), 1);
        rst_ni = 1'b0;
        tick(1);
        check_eq("R11", "rirr cleared by reset", 32'(rirr), 0);
        check_eq("R11", "valid cleared by reset", 32'(dlv_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule